// File: doc/BRIEF.md
# Speculative Virtual-Channel and Switch Allocator

This block decides, each cycle, which flits of a small router may cross the crossbar and which packet heads are given a downstream virtual channel. Every input port offers at most one flit, tagged with its output port, whether it is a packet head, whether it is a tail, and (for non-head flits) the downstream virtual channel it already owns. Downstream buffer availability arrives as one ready bit per output virtual channel. The input buffers and the credit counters that produce these bits sit outside the block.

A packet head asks for a free virtual channel on its output. In the same cycle it also makes a speculative bid for the switch on that output. Switch allocation needs only the output port, so it does not wait for the channel choice. Flits that already own a channel make firm bids, and firm bids beat speculative ones. A speculative switch win counts only if the same input also wins virtual-channel allocation in that cycle. If it does not, the output stays idle for that cycle and the head tries again later. The block keeps a busy bit for every downstream virtual channel. A channel is marked busy when a head is given it and freed when a tail flit on it crosses the switch.

Grants are combinational from the current requests and the registered state, so an input unit sees its grant in the cycle it asks. Arbitration state changes on the next clock edge.

Top module: `spec_alloc`

## Requirements
- R1: After reset every downstream virtual channel is free, and with no requests there are no virtual-channel grants, no switch grants and no active outputs.
- R2: A head flit that wins virtual-channel allocation receives the lowest-numbered channel on its output that is both free and credit-ready. That channel reads busy on `vc_busy_o` bit (output*NVC + channel) from the next cycle.
- R3: When no channel on the requested output is both free and credit-ready, no head on that output receives a virtual-channel grant, and no speculative switch grant is used there.
- R4: A speculative switch grant is used only when the same input wins virtual-channel allocation in the same cycle. Otherwise that output forwards nothing in that cycle.
- R5: A non-head flit bids for the switch only while the credit-ready bit of its owned channel (bit output*NVC + channel of `credit_ok_i`) is high.
- R6: When an output has any firm (non-head) bid, a firm bid wins the switch over every speculative head bid for that output.
- R7: Each output picks its switch winner round-robin. The search starts at a pointer that moves to one past the winner only when the grant is used. A wasted speculative win leaves the pointer in place.
- R8: A tail flit granted the switch frees its channel in the next cycle. This includes a single-flit packet that is head and tail at once.
- R9: At most one flit per output and one per input is granted per cycle. `out_vld_o[o]` is high exactly when some input is granted toward output o, and `out_src_o` names that input.
- R10: Virtual-channel allocation picks among heads round-robin with its own pointer per output. That pointer advances past the winner only when a channel is actually granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | NPORT | Input port p offers a flit |
| req_head_i | input | NPORT | Offered flit is a packet head needing a channel |
| req_tail_i | input | NPORT | Offered flit is the last of its packet |
| req_out_i | input | NPORT*IW | Output port of each input's flit, field p at [p*IW +: IW] |
| req_vc_i | input | NPORT*VW | Owned downstream channel of a non-head flit |
| credit_ok_i | input | NPORT*NVC | Downstream channel has buffer space, bit o*NVC+v |
| va_gnt_o | output | NPORT | Head at input p was given a channel |
| va_vc_o | output | NPORT*VW | Channel given to input p |
| sa_gnt_o | output | NPORT | Flit at input p crosses the switch this cycle |
| sa_vc_o | output | NPORT*VW | Downstream channel the crossing flit travels on |
| out_vld_o | output | NPORT | Output o forwards a flit this cycle |
| out_src_o | output | NPORT*IW | Input selected for output o |
| vc_busy_o | output | NPORT*NVC | Busy state of each downstream channel |

## Verification
The checker watches several conditions on every cycle. A given channel must have been free. A speculative switch win is only used together with a channel grant to the same input on the channel it reports. A firm crossing requires credit. Channels change state correctly after a grant and after a tail. The count of granted inputs matches the count of active outputs. Only the directed scenarios can show the rest: the order of round-robin winners, and that a wasted or failed cycle leaves both pointers where they were. They also show which channel number is picked first and that a firm bid displaces a speculative one. Each of these depends on a history of earlier grants that a single-cycle property cannot see.

// File: rtl/spec_alloc_pkg.sv
package spec_alloc_pkg;

    // Classification of one input's offer in the current cycle
    typedef enum logic [1:0] {
        REQ_IDLE = 2'd0,
        REQ_SPEC = 2'd1,
        REQ_FIRM = 2'd2
    } req_cls_e;

    // Round-robin successor of a winner index in a ring of n entries
    function automatic int rr_next(input int idx, input int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/spec_alloc_rr.sv
// Combinational round-robin pick: first set request at or after ptr.
module spec_alloc_rr #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = (int'(ptr) + k) % N;
            if (!any && req[c]) begin
                any = 1'b1;
                idx = IW'(c);
            end
        end
    end
endmodule

// File: rtl/spec_alloc_out.sv
// Per-output allocation: firm and speculative switch arbitration plus
// virtual-channel arbitration, resolved against each other.
module spec_alloc_out #(
    parameter int NPORT = 5,
    parameter int NVC   = 2,
    parameter int IW    = 3,
    parameter int VW    = 1
) (
    input  logic [NPORT-1:0] firm_req,
    input  logic [NPORT-1:0] spec_req,
    input  logic [IW-1:0]    sa_ptr,
    input  logic [IW-1:0]    va_ptr,
    input  logic [NVC-1:0]   vc_ok,
    output logic             sa_used,
    output logic [IW-1:0]    sa_idx,
    output logic             sa_spec,
    output logic             va_ok,
    output logic [IW-1:0]    va_idx,
    output logic [VW-1:0]    va_vc
);
    logic          f_any, s_any, h_any;
    logic [IW-1:0] f_idx, s_idx, h_idx;
    logic          vc_found;
    logic [VW-1:0] vc_sel;

    spec_alloc_rr #(.N(NPORT), .IW(IW)) i_firm_arb (
        .req(firm_req), .ptr(sa_ptr), .any(f_any), .idx(f_idx)
    );
    spec_alloc_rr #(.N(NPORT), .IW(IW)) i_spec_arb (
        .req(spec_req), .ptr(sa_ptr), .any(s_any), .idx(s_idx)
    );
    spec_alloc_rr #(.N(NPORT), .IW(IW)) i_head_arb (
        .req(spec_req), .ptr(va_ptr), .any(h_any), .idx(h_idx)
    );

    // Lowest-numbered eligible channel
    always_comb begin
        vc_found = 1'b0;
        vc_sel   = '0;
        for (int v = NVC - 1; v >= 0; v--) begin
            if (vc_ok[v]) begin
                vc_found = 1'b1;
                vc_sel   = VW'(v);
            end
        end
    end

    always_comb begin
        va_ok   = h_any && vc_found;
        va_idx  = h_idx;
        va_vc   = vc_sel;
        sa_spec = !f_any;
        sa_idx  = f_any ? f_idx : s_idx;
        sa_used = f_any || (s_any && va_ok && (h_idx == s_idx));
    end
endmodule

// File: rtl/spec_alloc.sv
module spec_alloc
    import spec_alloc_pkg::*;
#(
    parameter int  NPORT = 5,
    parameter int  NVC   = 2,
    localparam int IW    = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int VW    = (NVC > 1) ? $clog2(NVC) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NPORT-1:0]     req_valid_i,
    input  logic [NPORT-1:0]     req_head_i,
    input  logic [NPORT-1:0]     req_tail_i,
    input  logic [NPORT*IW-1:0]  req_out_i,
    input  logic [NPORT*VW-1:0]  req_vc_i,
    input  logic [NPORT*NVC-1:0] credit_ok_i,
    output logic [NPORT-1:0]     va_gnt_o,
    output logic [NPORT*VW-1:0]  va_vc_o,
    output logic [NPORT-1:0]     sa_gnt_o,
    output logic [NPORT*VW-1:0]  sa_vc_o,
    output logic [NPORT-1:0]     out_vld_o,
    output logic [NPORT*IW-1:0]  out_src_o,
    output logic [NPORT*NVC-1:0] vc_busy_o
);
    localparam int NB = NPORT * NVC;

    typedef struct packed {
        logic [NB-1:0]       busy;
        logic [NPORT*IW-1:0] sa_ptr;
        logic [NPORT*IW-1:0] va_ptr;
    } alloc_st_t;

    alloc_st_t st_d, st_q;

    req_cls_e         cls      [NPORT];
    logic [NPORT-1:0] firm_m   [NPORT];
    logic [NPORT-1:0] spec_m   [NPORT];
    logic [NVC-1:0]   vc_ok    [NPORT];
    logic             sa_used  [NPORT];
    logic [IW-1:0]    sa_idx   [NPORT];
    logic             sa_spec  [NPORT];
    logic             va_ok    [NPORT];
    logic [IW-1:0]    va_idx   [NPORT];
    logic [VW-1:0]    va_vc    [NPORT];

    // Request decode: sort each input's offer into per-output bid masks
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            firm_m[o] = '0;
            spec_m[o] = '0;
        end
        for (int p = 0; p < NPORT; p++) begin
            int o;
            int v;
            o = int'(req_out_i[p*IW +: IW]);
            v = int'(req_vc_i[p*VW +: VW]);
            cls[p] = REQ_IDLE;
            if (req_valid_i[p] && o < NPORT) begin
                if (req_head_i[p]) begin
                    cls[p] = REQ_SPEC;
                end else if (v < NVC && credit_ok_i[o*NVC + v]) begin
                    cls[p] = REQ_FIRM;
                end
            end
            if (cls[p] == REQ_SPEC) spec_m[o][p] = 1'b1;
            if (cls[p] == REQ_FIRM) firm_m[o][p] = 1'b1;
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        assign vc_ok[o] = credit_ok_i[o*NVC +: NVC] & ~st_q.busy[o*NVC +: NVC];

        spec_alloc_out #(
            .NPORT(NPORT), .NVC(NVC), .IW(IW), .VW(VW)
        ) i_out (
            .firm_req (firm_m[o]),
            .spec_req (spec_m[o]),
            .sa_ptr   (st_q.sa_ptr[o*IW +: IW]),
            .va_ptr   (st_q.va_ptr[o*IW +: IW]),
            .vc_ok    (vc_ok[o]),
            .sa_used  (sa_used[o]),
            .sa_idx   (sa_idx[o]),
            .sa_spec  (sa_spec[o]),
            .va_ok    (va_ok[o]),
            .va_idx   (va_idx[o]),
            .va_vc    (va_vc[o])
        );
    end

    // Outcome and next state
    always_comb begin
        logic [NB-1:0] set_m;
        logic [NB-1:0] clr_m;
        st_d      = st_q;
        set_m     = '0;
        clr_m     = '0;
        va_gnt_o  = '0;
        va_vc_o   = '0;
        sa_gnt_o  = '0;
        sa_vc_o   = '0;
        out_vld_o = '0;
        out_src_o = '0;
        for (int o = 0; o < NPORT; o++) begin
            int p;
            int h;
            logic [VW-1:0] fv;
            p  = int'(sa_idx[o]);
            h  = int'(va_idx[o]);
            fv = sa_spec[o] ? va_vc[o] : req_vc_i[p*VW +: VW];
            if (va_ok[o]) begin
                va_gnt_o[h]            = 1'b1;
                va_vc_o[h*VW +: VW]    = va_vc[o];
                set_m[o*NVC + int'(va_vc[o])] = 1'b1;
                st_d.va_ptr[o*IW +: IW] = IW'(rr_next(h, NPORT));
            end
            if (sa_used[o]) begin
                sa_gnt_o[p]             = 1'b1;
                sa_vc_o[p*VW +: VW]     = fv;
                out_vld_o[o]            = 1'b1;
                out_src_o[o*IW +: IW]   = sa_idx[o];
                if (req_tail_i[p]) clr_m[o*NVC + int'(fv)] = 1'b1;
                st_d.sa_ptr[o*IW +: IW] = IW'(rr_next(p, NPORT));
            end
        end
        st_d.busy = (st_q.busy | set_m) & ~clr_m;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vc_busy_o = st_q.busy;

endmodule

// File: rtl/spec_alloc_chk.sv
module spec_alloc_chk #(
    parameter int  NPORT = 5,
    parameter int  NVC   = 2,
    localparam int IW    = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int VW    = (NVC > 1) ? $clog2(NVC) : 1
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NPORT-1:0]     req_head_i,
    input logic [NPORT-1:0]     req_tail_i,
    input logic [NPORT*IW-1:0]  req_out_i,
    input logic [NPORT*VW-1:0]  req_vc_i,
    input logic [NPORT*NVC-1:0] credit_ok_i,
    input logic [NPORT-1:0]     va_gnt_o,
    input logic [NPORT*VW-1:0]  va_vc_o,
    input logic [NPORT-1:0]     sa_gnt_o,
    input logic [NPORT*VW-1:0]  sa_vc_o,
    input logic [NPORT-1:0]     out_vld_o,
    input logic [NPORT*NVC-1:0] vc_busy_o
);
    localparam int NB = NPORT * NVC;

    // R9: granted inputs and active outputs agree in number
    a_r9_one_to_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(sa_gnt_o) == $countones(out_vld_o));

    for (genvar p = 0; p < NPORT; p++) begin : g_in
        int va_bit, sa_bit, nh_bit;
        logic [$clog2(NB+1)-1:0] va_bit_q, sa_bit_q;
        assign va_bit = int'(req_out_i[p*IW +: IW]) * NVC + int'(va_vc_o[p*VW +: VW]);
        assign sa_bit = int'(req_out_i[p*IW +: IW]) * NVC + int'(sa_vc_o[p*VW +: VW]);
        assign nh_bit = int'(req_out_i[p*IW +: IW]) * NVC + int'(req_vc_i[p*VW +: VW]);

        always_ff @(posedge clk_i) begin
            va_bit_q <= ($clog2(NB+1))'(va_bit);
            sa_bit_q <= ($clog2(NB+1))'(sa_bit);
        end

        // R2: a channel is given only while free
        a_r2_gives_free_vc: assert property (@(posedge clk_i) disable iff (!rst_ni)
            va_gnt_o[p] |-> !vc_busy_o[va_bit]);

        // R2: a given channel reads busy afterwards unless its tail already left
        a_r2_marks_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (va_gnt_o[p] && !(sa_gnt_o[p] && req_tail_i[p])) |=> vc_busy_o[va_bit_q]);

        // R4: a speculative switch use needs this input's channel grant
        a_r4_spec_needs_va: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sa_gnt_o[p] && req_head_i[p]) |->
                (va_gnt_o[p] && va_vc_o[p*VW +: VW] == sa_vc_o[p*VW +: VW]));

        // R5: a firm crossing needs credit on its owned channel
        a_r5_firm_has_credit: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sa_gnt_o[p] && !req_head_i[p]) |-> credit_ok_i[nh_bit]);

        // R8: a tail that crosses frees its channel
        a_r8_tail_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sa_gnt_o[p] && req_tail_i[p]) |=> !vc_busy_o[sa_bit_q]);
    end
endmodule

bind spec_alloc spec_alloc_chk #(.NPORT(NPORT), .NVC(NVC)) i_chk (.*);

// File: tb/test_spec_alloc.sv
`timescale 1ns/1ps
module test_spec_alloc;
    localparam int NPORT = 5;
    localparam int NVC   = 2;
    localparam int IW    = 3;
    localparam int VW    = 1;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [NPORT-1:0]     req_valid, req_head, req_tail;
    logic [NPORT*IW-1:0]  req_out;
    logic [NPORT*VW-1:0]  req_vc;
    logic [NPORT*NVC-1:0] credit_ok;
    logic [NPORT-1:0]     va_gnt, sa_gnt, out_vld;
    logic [NPORT*VW-1:0]  va_vc, sa_vc;
    logic [NPORT*IW-1:0]  out_src;
    logic [NPORT*NVC-1:0] vc_busy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    spec_alloc #(.NPORT(NPORT), .NVC(NVC)) i_spec_alloc (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_head_i(req_head), .req_tail_i(req_tail),
        .req_out_i(req_out), .req_vc_i(req_vc), .credit_ok_i(credit_ok),
        .va_gnt_o(va_gnt), .va_vc_o(va_vc), .sa_gnt_o(sa_gnt), .sa_vc_o(sa_vc),
        .out_vld_o(out_vld), .out_src_o(out_src), .vc_busy_o(vc_busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_req();
        req_valid = '0; req_head = '0; req_tail = '0;
        req_out   = '0; req_vc   = '0;
    endtask

    task automatic set_req(input int p, input bit h, input bit t, input int o, input int v);
        req_valid[p] = 1'b1;
        req_head[p]  = h;
        req_tail[p]  = t;
        req_out[p*IW +: IW] = IW'(o);
        req_vc[p*VW +: VW]  = VW'(v);
    endtask

    // Let the edge pass, drop the requests, settle
    task automatic advance();
        @(negedge clk);
        clear_req();
        #1;
    endtask

    task automatic t_reset();
        chk("R1 va_gnt", int'(va_gnt), 0);
        chk("R1 sa_gnt", int'(sa_gnt), 0);
        chk("R1 out_vld", int'(out_vld), 0);
        chk("R1 vc_busy", int'(vc_busy), 0);
    endtask

    task automatic t_head_alloc();
        set_req(1, 1, 0, 3, 0); #1;
        chk("R2 va_gnt first head", int'(va_gnt), 5'b00010);
        chk("R2 va_vc lowest", int'(va_vc[1]), 0);
        chk("R4 spec used", int'(sa_gnt), 5'b00010);
        chk("R9 out3 src", int'(out_src[3*IW +: IW]), 1);
        advance();
        chk("R2 vc 3.0 busy", int'(vc_busy[6]), 1);
        set_req(2, 1, 0, 3, 0); #1;
        chk("R2 second head gets vc1", int'(va_vc[2]), 1);
        chk("R2 second head granted", int'(sa_gnt), 5'b00100);
        advance();
        chk("R2 vc 3.1 busy", int'(vc_busy[7]), 1);
    endtask

    task automatic t_va_fail();
        set_req(4, 1, 0, 3, 0); #1;
        chk("R3 no vc grant", int'(va_gnt), 0);
        chk("R3 no switch grant", int'(sa_gnt), 0);
        chk("R3 out3 idle", int'(out_vld[3]), 0);
        advance();
        chk("R3 busy unchanged", int'(vc_busy[7:6]), 3);
    endtask

    task automatic t_tail_free();
        set_req(1, 0, 1, 3, 0); #1;
        chk("R8 tail crosses", int'(sa_gnt), 5'b00010);
        chk("R8 tail vc", int'(sa_vc[1]), 0);
        advance();
        chk("R8 vc 3.0 freed", int'(vc_busy[6]), 0);
        chk("R8 vc 3.1 kept", int'(vc_busy[7]), 1);
        set_req(4, 1, 0, 3, 0); #1;
        chk("R2 freed vc reused", int'(va_gnt), 5'b10000);
        chk("R2 freed vc number", int'(va_vc[4]), 0);
        advance();
    endtask

    task automatic t_priority_mismatch();
        // out0: speculative head on input 0, firm flit on input 2
        set_req(0, 1, 0, 0, 0);
        set_req(2, 0, 0, 0, 1); #1;
        chk("R6 firm wins switch", int'(sa_gnt), 5'b00100);
        chk("R6 out0 source", int'(out_src[0 +: IW]), 2);
        chk("R6 head still gets vc", int'(va_gnt), 5'b00001);
        advance();
        // sa pointer now 3, va pointer now 1: the two pick different heads
        set_req(1, 1, 0, 0, 0);
        set_req(4, 1, 0, 0, 0); #1;
        chk("R10 va winner input1", int'(va_gnt), 5'b00010);
        chk("R10 va vc1", int'(va_vc[1]), 1);
        chk("R4 mismatch wastes slot", int'(sa_gnt), 0);
        chk("R4 out0 idle", int'(out_vld[0]), 0);
        advance();
        // wasted win must not move the switch pointer (still 3)
        set_req(0, 0, 0, 0, 0);
        set_req(4, 0, 0, 0, 0); #1;
        chk("R7 pointer held after waste", int'(out_src[0 +: IW]), 4);
        advance();
    endtask

    task automatic t_credit();
        credit_ok[2] = 1'b0;
        set_req(3, 0, 0, 1, 0); #1;
        chk("R5 no credit no grant", int'(sa_gnt), 0);
        chk("R5 out1 idle", int'(out_vld[1]), 0);
        credit_ok[2] = 1'b1; #1;
        chk("R5 credit back grants", int'(sa_gnt), 5'b01000);
        advance();
        set_req(3, 1, 1, 1, 0); #1;
        chk("R8 single flit granted", int'(sa_gnt), 5'b01000);
        chk("R8 single flit vc", int'(va_vc[3]), 0);
        advance();
        chk("R8 single flit leaves vc free", int'(vc_busy[2]), 0);
    endtask

    task automatic t_round_robin();
        for (int k = 0; k < 4; k++) begin
            set_req(0, 0, 0, 2, 0);
            set_req(1, 0, 0, 2, 0);
            set_req(2, 0, 0, 2, 0); #1;
            chk("R7 rotation", int'(out_src[2*IW +: IW]), k % 3);
            chk("R9 single grant", $countones(sa_gnt), 1);
            advance();
        end
    endtask

    task automatic t_va_pointer();
        set_req(0, 1, 0, 4, 0); #1; advance();
        set_req(1, 1, 0, 4, 0); #1; advance();
        chk("R2 out4 both busy", int'(vc_busy[9:8]), 3);
        set_req(0, 1, 0, 4, 0);
        set_req(3, 1, 0, 4, 0); #1;
        chk("R3 out4 no vc", int'(va_gnt), 0);
        chk("R3 out4 no switch", int'(sa_gnt), 0);
        advance();
        set_req(0, 0, 1, 4, 0); #1;
        chk("R8 out4 tail", int'(sa_gnt), 5'b00001);
        advance();
        set_req(0, 1, 0, 4, 0);
        set_req(3, 1, 0, 4, 0); #1;
        chk("R10 va pointer held on failure", int'(va_gnt), 5'b01000);
        chk("R10 vc number", int'(va_vc[3]), 0);
        chk("R4 matched spec used", int'(sa_gnt), 5'b01000);
        advance();
    endtask

    initial begin
        rst_n = 1'b0;
        credit_ok = '1;
        clear_req();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_head_alloc();
        t_va_fail();
        t_tail_free();
        t_priority_mismatch();
        t_credit();
        t_round_robin();
        t_va_pointer();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule